// File: doc/BRIEF.md
# Serial Character Transmitter with Break Generation

This block turns characters into an asynchronous serial stream. Characters of 8 or 9 bits enter through a single-cycle write strobe and wait in a four-slot holding buffer. A shift engine takes them from the buffer one at a time. Each frame is a low start bit, the data bits with the least significant bit first, and one high stop bit. Every bit lasts 16 pulses of an external baud tick. A pending break request takes priority over queued characters. It produces a frame that holds the line low for 13 bit times, followed by a stop bit, and the request then clears itself.

A registered interrupt pulse reports one of three events, selected by a 2-bit mode input. The events are a character leaving the buffer, the last frame finishing with nothing queued, and a hand-off that empties the buffer. The block also outputs buffer-full, line-idle and sticky overflow status. Dropping the enable aborts the current frame, flushes the buffer and parks the line at its idle level. When encoder mode is on, an inversion input makes the idle level 0.

The shift engine has five states. IDLE holds the line high. It moves to START on a break request (flag kept) or on a buffered character (the character is popped and loaded). START drives the line low for one bit, then goes to BREAK if the frame is a break and to DATA otherwise. DATA shifts out 8 or 9 bits and then goes to STOP. BREAK holds the line low for 12 bits and then goes to STOP. STOP drives the line high for one bit and returns to IDLE. A low enable forces any state back to IDLE.

Top module: `uart_tx_brk`

## Requirements
- R1: An 8-bit frame is one low start bit, then data bits 0 to 7 in that order, then one high stop bit. Each bit lasts 16 baud ticks.
- R2: When `nine_bit` is 1 at the moment a character is loaded, data bit 8 is sent after bit 7 and before the stop bit.
- R3: The buffer holds four characters and `buf_full` is 1 exactly when all four slots are taken. A write while full is dropped and sets `overflow`, which stays 1 until `tx_en` goes low.
- R4: `shifter_empty` is 1 only when no frame is in progress and the buffer is empty. While it is 1, `txd` is at the idle level.
- R5: With `irq_mode` = 00, `irq` pulses once for every character moved from the buffer into the shift engine.
- R6: With `irq_mode` = 01, `irq` pulses once when a frame's stop bit ends and the buffer is empty.
- R7: With `irq_mode` = 10, `irq` pulses when a character hand-off leaves the buffer empty. A hand-off in the same cycle as an accepted write does not count.
- R8: `irq_mode` = 11 never raises `irq`.
- R9: A pulse on `brk_set` raises `brk_pending`. The next frame is a start bit, twelve low bits and a stop bit, and it is sent ahead of queued characters. `brk_pending` clears when that frame's stop bit ends.
- R10: With `tx_en` low, the current frame is aborted, the buffer is emptied, writes are dropped and `txd` stays at the idle level.
- R11: When `enc_en` and `idle_inv` are both 1, `txd` is inverted, so it idles at 0. `idle_inv` has no effect when `enc_en` is 0.
- R12: After reset, `txd` = 1, `buf_full` = 0, `shifter_empty` = 1, and `irq`, `overflow` and `brk_pending` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmit enable; low aborts and flushes |
| baud_tick | input | 1 | Baud tick, 16 per bit |
| wr_en | input | 1 | Write strobe for one character |
| wr_data | input | 9 | Character; bit 8 is used only in 9-bit mode |
| nine_bit | input | 1 | 9-bit character mode |
| brk_set | input | 1 | Break request pulse |
| irq_mode | input | 2 | Interrupt event select |
| enc_en | input | 1 | Encoder mode; enables the inversion |
| idle_inv | input | 1 | Output inversion select |
| txd | output | 1 | Serial output |
| buf_full | output | 1 | Buffer has no free slot |
| shifter_empty | output | 1 | No frame in progress and buffer empty |
| overflow | output | 1 | Sticky flag for a dropped write |
| brk_pending | output | 1 | Break request not yet completed |
| irq | output | 1 | Interrupt pulse |

## Verification
Frames are decoded from `txd` at mid-bit and compared with a queue of expected items. The data patterns are 0x55, 0xA3, 0x00, 0xFF and 9-bit values with bit 8 set. Together they catch wrong bit order, stuck bits and a ninth bit in the wrong slot. A six-write burst fills the buffer, checks that the sixth write is dropped, and shows whether the 00 mode counts every hand-off. A single write followed by a burst separates mode 10 (buffer left empty) from mode 00. A burst under mode 01 shows whether only the final frame is reported. A break requested together with a character checks both the ordering and the 13-bit low period. An enable drop in the middle of a frame, and an inverted-idle frame, cover the abort and polarity paths.

// File: rtl/utx_pkg.sv
package utx_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_START,
        S_DATA,
        S_BREAK,
        S_STOP
    } tx_state_e;

    localparam logic [1:0] IRQ_ON_LOAD  = 2'b00;
    localparam logic [1:0] IRQ_ON_DONE  = 2'b01;
    localparam logic [1:0] IRQ_ON_EMPTY = 2'b10;
endpackage

// File: rtl/utx_fifo.sv
module utx_fifo #(
    parameter int W     = 9,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr,
    input  logic [W-1:0]                 wdata,
    input  logic                         rd,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty,
    output logic                         wr_ok,
    output logic                         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic          rd_ok;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign wr_ok = wr && !full && !clr;
    assign rd_ok = rd && !empty && !clr;
    assign rdata = mem[rptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (wr_ok)
                wptr <= (wptr == PW'(DEPTH-1)) ? '0 : wptr + 1'b1;
            if (rd_ok)
                rptr <= (rptr == PW'(DEPTH-1)) ? '0 : rptr + 1'b1;
            case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr && full)
                ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok)
            mem[wptr] <= wdata;
    end

    // A write into a full buffer must not change the occupancy
    assert_full_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && wr && !rd && !clr) |=> (count == CW'(DEPTH)) && ovf);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
#(
    parameter int W        = 9,
    parameter int TICKS    = 16,
    parameter int BRK_BITS = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick,
    input  logic         have_data,
    input  logic         brk_pend,
    input  logic [W-1:0] din,
    input  logic         nine,
    output logic         pop,
    output logic         line,
    output logic         busy,
    output logic         frame_done,
    output logic         brk_done
);
    localparam int TW   = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam int MAXB = (BRK_BITS > W) ? BRK_BITS : W;
    localparam int BCW  = $clog2(MAXB + 1);

    tx_state_e      state, state_nx;
    logic [TW-1:0]  tick_cnt;
    logic [BCW-1:0] bit_cnt;
    logic [W-1:0]   shreg;
    logic           nine_q, brk_q;
    logic           bit_end, last_data, last_brk;

    assign bit_end   = tick && (tick_cnt == TW'(TICKS-1));
    assign last_data = (bit_cnt == (nine_q ? BCW'(W-1) : BCW'(W-2)));
    assign last_brk  = (bit_cnt == BCW'(BRK_BITS-1));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= S_IDLE;
        else
            state <= state_nx;
    end

    // Next state
    always_comb begin
        state_nx = state;
        if (!en) begin
            state_nx = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:  if (brk_pend || have_data) state_nx = S_START;
                S_START: if (bit_end) state_nx = brk_q ? S_BREAK : S_DATA;
                S_DATA:  if (bit_end && last_data) state_nx = S_STOP;
                S_BREAK: if (bit_end && last_brk) state_nx = S_STOP;
                S_STOP:  if (bit_end) state_nx = S_IDLE;
                default: state_nx = S_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_cnt <= '0;
            bit_cnt  <= '0;
            shreg    <= '0;
            nine_q   <= 1'b0;
            brk_q    <= 1'b0;
        end else if (!en || state == S_IDLE) begin
            tick_cnt <= '0;
            bit_cnt  <= '0;
            if (en && brk_pend) begin
                brk_q <= 1'b1;
            end else if (en && have_data) begin
                brk_q  <= 1'b0;
                shreg  <= din;
                nine_q <= nine;
            end
        end else if (tick) begin
            tick_cnt <= bit_end ? '0 : tick_cnt + 1'b1;
            if (bit_end) begin
                if (state == S_DATA || state == S_BREAK)
                    bit_cnt <= bit_cnt + 1'b1;
                else
                    bit_cnt <= '0;
                if (state == S_DATA)
                    shreg <= shreg >> 1;
            end
        end
    end

    // Outputs
    always_comb begin
        pop        = 1'b0;
        line       = 1'b1;
        frame_done = 1'b0;
        brk_done   = 1'b0;
        unique case (state)
            S_IDLE:  pop  = en && !brk_pend && have_data;
            S_START: line = 1'b0;
            S_DATA:  line = shreg[0];
            S_BREAK: line = 1'b0;
            S_STOP: begin
                line       = 1'b1;
                frame_done = en && bit_end;
                brk_done   = en && bit_end && brk_q;
            end
            default: line = 1'b1;
        endcase
    end

    assign busy = (state != S_IDLE);

    // A low enable returns the engine to IDLE on the next edge
    assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state == S_IDLE));
endmodule

// File: rtl/uart_tx_brk.sv
module uart_tx_brk
    import utx_pkg::*;
#(
    parameter int DATA_W   = 9,
    parameter int DEPTH    = 4,
    parameter int TICKS    = 16,
    parameter int BRK_BITS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_en,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              nine_bit,
    input  logic              brk_set,
    input  logic [1:0]        irq_mode,
    input  logic              enc_en,
    input  logic              idle_inv,
    output logic              txd,
    output logic              buf_full,
    output logic              shifter_empty,
    output logic              overflow,
    output logic              brk_pending,
    output logic              irq
);
    localparam int CW = $clog2(DEPTH+1);

    logic [DATA_W-1:0] q_data;
    logic [CW-1:0]     q_count;
    logic              q_empty, q_wr_ok, pop;
    logic              line, busy, frame_done, brk_done;
    logic              inv, irq_ev;

    utx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!tx_en),
        .wr    (wr_en),
        .wdata (wr_data),
        .rd    (pop),
        .rdata (q_data),
        .count (q_count),
        .full  (buf_full),
        .empty (q_empty),
        .wr_ok (q_wr_ok),
        .ovf   (overflow)
    );

    utx_shifter #(.W(DATA_W), .TICKS(TICKS), .BRK_BITS(BRK_BITS)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (tx_en),
        .tick       (baud_tick),
        .have_data  (!q_empty),
        .brk_pend   (brk_pending),
        .din        (q_data),
        .nine       (nine_bit),
        .pop        (pop),
        .line       (line),
        .busy       (busy),
        .frame_done (frame_done),
        .brk_done   (brk_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            brk_pending <= 1'b0;
        else if (!tx_en)
            brk_pending <= 1'b0;
        else if (brk_set)
            brk_pending <= 1'b1;
        else if (brk_done)
            brk_pending <= 1'b0;
    end

    always_comb begin
        unique case (irq_mode)
            IRQ_ON_LOAD:  irq_ev = pop;
            IRQ_ON_DONE:  irq_ev = frame_done && q_empty;
            IRQ_ON_EMPTY: irq_ev = pop && (q_count == CW'(1)) && !q_wr_ok;
            default:      irq_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            irq <= 1'b0;
        else
            irq <= irq_ev;
    end

    assign inv           = enc_en && idle_inv;
    assign shifter_empty = !busy && q_empty;
    assign txd           = (tx_en ? line : 1'b1) ^ inv;

    assert_empty_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shifter_empty |-> (txd == !inv));

    assert_mode3_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_mode) == 2'b11) |-> !irq);

    assert_load_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(irq_mode) == 2'b00 && $past(tx_en) && tx_en) |-> busy);
endmodule

// File: tb/sim_uart_tx_brk.sv
module sim_uart_tx_brk;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_en = 1'b0;
    logic       baud_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [8:0] wr_data = '0;
    logic       nine_bit = 1'b0;
    logic       brk_set = 1'b0;
    logic [1:0] irq_mode = 2'b00;
    logic       enc_en = 1'b0;
    logic       idle_inv = 1'b0;
    logic       txd, buf_full, shifter_empty, overflow, brk_pending, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int irq_cnt = 0;
    bit mon_on  = 1'b1;
    bit finished = 1'b0;

    // expected item: {is_break, nine, data[8:0]}
    logic [10:0] exp_q[$];

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) baud_tick <= ~baud_tick;

    uart_tx_brk u0 (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .baud_tick(baud_tick),
        .wr_en(wr_en), .wr_data(wr_data), .nine_bit(nine_bit),
        .brk_set(brk_set), .irq_mode(irq_mode), .enc_en(enc_en),
        .idle_inv(idle_inv), .txd(txd), .buf_full(buf_full),
        .shifter_empty(shifter_empty), .overflow(overflow),
        .brk_pending(brk_pending), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [8:0] d, input logic nb, input bit expect_it);
        wr_en    = 1'b1;
        wr_data  = d;
        nine_bit = nb;
        if (expect_it) exp_q.push_back({1'b0, nb, d});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        while (!shifter_empty) @(negedge clk);
        repeat (8) @(negedge clk);
    endtask

    always @(negedge clk) if (irq) irq_cnt++;

    // Monitor: decode frames from the line and compare with the queue
    initial begin : monitor
        logic        prev;
        logic        ln;
        logic [10:0] it;
        logic [8:0]  got;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            ln = txd ^ (enc_en & idle_inv);
            if (mon_on && tx_en && prev && !ln) begin
                if (exp_q.size() == 0) begin
                    it = '0;
                    check("R1 unexpected frame", 16'd1, 16'd0);
                end else begin
                    it = exp_q.pop_front();
                end
                repeat (16) @(negedge clk);
                check("R1 start bit", 16'(txd ^ (enc_en & idle_inv)), 16'd0);
                if (it[10]) begin
                    for (int i = 0; i < 12; i++) begin
                        repeat (32) @(negedge clk);
                        check("R9 break bit low", 16'(txd ^ (enc_en & idle_inv)), 16'd0);
                    end
                end else begin
                    got = '0;
                    for (int i = 0; i < (it[9] ? 9 : 8); i++) begin
                        repeat (32) @(negedge clk);
                        got[i] = txd ^ (enc_en & idle_inv);
                    end
                    if (it[9]) check("R2 nine-bit data", 16'(got), 16'(it[8:0]));
                    else       check("R1 data", 16'(got), 16'(it[7:0]));
                end
                repeat (32) @(negedge clk);
                check(it[10] ? "R9 stop after break" : "R1 stop bit",
                      16'(txd ^ (enc_en & idle_inv)), 16'd1);
                ln = 1'b1;
            end
            prev = ln;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 txd", 16'(txd), 16'd1);
        check("R12 buf_full", 16'(buf_full), 16'd0);
        check("R12 shifter_empty", 16'(shifter_empty), 16'd1);
        check("R12 irq/ovf/brk", 16'({irq, overflow, brk_pending}), 16'd0);

        tx_en = 1'b1;
        @(negedge clk);
        // R1 several patterns, R2 nine-bit
        put(9'h055, 1'b0, 1'b1); wait_idle();
        put(9'h0A3, 1'b0, 1'b1); wait_idle();
        put(9'h000, 1'b0, 1'b1); wait_idle();
        put(9'h1FF, 1'b0, 1'b1); wait_idle();
        put(9'h1A5, 1'b1, 1'b1); wait_idle();
        put(9'h0FF, 1'b1, 1'b1); wait_idle();

        // R3 / R5: burst of six, sixth dropped; mode 00 counts hand-offs
        irq_mode = 2'b00;
        base = irq_cnt;
        put(9'h011, 1'b0, 1'b1);
        put(9'h022, 1'b0, 1'b1);
        put(9'h033, 1'b0, 1'b1);
        put(9'h044, 1'b0, 1'b1);
        check("R3 not full at three queued", 16'(buf_full), 16'd0);
        put(9'h066, 1'b0, 1'b1);
        check("R3 full", 16'(buf_full), 16'd1);
        check("R3 no overflow yet", 16'(overflow), 16'd0);
        put(9'h077, 1'b0, 1'b0);
        check("R3 overflow set", 16'(overflow), 16'd1);
        check("R4 shifter_empty busy", 16'(shifter_empty), 16'd0);
        wait_idle();
        check("R5 irq count mode 00", 16'(irq_cnt - base), 16'd5);
        check("R3 overflow sticky", 16'(overflow), 16'd1);
        check("R4 shifter_empty idle", 16'(shifter_empty), 16'd1);

        // R7: single write then burst of three
        irq_mode = 2'b10;
        base = irq_cnt;
        put(9'h0C3, 1'b0, 1'b1); wait_idle();
        put(9'h081, 1'b0, 1'b1);
        put(9'h042, 1'b0, 1'b1);
        put(9'h024, 1'b0, 1'b1);
        wait_idle();
        check("R7 irq count mode 10", 16'(irq_cnt - base), 16'd2);

        // R6: burst of three reports only the end
        irq_mode = 2'b01;
        base = irq_cnt;
        put(9'h0E7, 1'b0, 1'b1);
        put(9'h018, 1'b0, 1'b1);
        put(9'h099, 1'b0, 1'b1);
        wait_idle();
        check("R6 irq count mode 01", 16'(irq_cnt - base), 16'd1);

        // R9: break requested with a character; break goes first
        base = irq_cnt;
        brk_set = 1'b1;
        exp_q.push_back({1'b1, 1'b0, 9'h000});
        put(9'h05A, 1'b0, 1'b1);
        brk_set = 1'b0;
        check("R9 brk_pending set", 16'(brk_pending), 16'd1);
        wait_idle();
        check("R9 brk_pending cleared", 16'(brk_pending), 16'd0);
        check("R6 one irq after break+char", 16'(irq_cnt - base), 16'd1);

        // R8: reserved mode is silent
        irq_mode = 2'b11;
        base = irq_cnt;
        put(9'h0AA, 1'b0, 1'b1);
        put(9'h0BB, 1'b0, 1'b1);
        wait_idle();
        check("R8 irq count mode 11", 16'(irq_cnt - base), 16'd0);

        // R10: abort in mid-frame
        mon_on = 1'b0;
        put(9'h081, 1'b0, 1'b0);
        put(9'h0F0, 1'b0, 1'b0);
        repeat (100) @(negedge clk);
        tx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R10 txd idle on abort", 16'(txd), 16'd1);
        check("R10 flushed", 16'({shifter_empty, buf_full, overflow}), 16'b100);
        put(9'h033, 1'b0, 1'b0);
        check("R10 write dropped when disabled", 16'(shifter_empty), 16'd1);
        tx_en = 1'b1;
        repeat (400) @(negedge clk);
        check("R10 nothing resumes", 16'({txd, shifter_empty}), 16'b11);
        mon_on = 1'b1;

        // R11: inversion only under encoder mode
        idle_inv = 1'b1;
        @(negedge clk);
        check("R11 no effect without encoder", 16'(txd), 16'd1);
        enc_en = 1'b1;
        @(negedge clk);
        check("R11 idle inverted", 16'(txd), 16'd0);
        put(9'h03C, 1'b0, 1'b1);
        wait_idle();
        check("R11 idle inverted after frame", 16'(txd), 16'd0);
        enc_en = 1'b0;
        idle_inv = 1'b0;

        repeat (4) @(negedge clk);
        check("R1 all expected frames seen", 16'(exp_q.size()), 16'd0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule